// File: doc/BRIEF.md
# Ranked Channel Interrupt Arbiter

This block sits beside eight receive channels and decides which one the host should service first. Each channel raises a one-cycle arrival strobe when a message lands. The strobe sets a sticky pending bit, and the pending bit stays set until the host acknowledges that channel. Every channel also owns a 4-bit rank that software writes through a small register port. Among the pending channels, the one with the numerically smallest rank wins.

The block raises an interrupt request while anything is pending. It reports the winning channel index and an 8-bit vector. The vector is the upper bits of a software-written vector base with the 3-bit winning index in its low bits. The choice is recomputed every cycle from registered state. Acknowledging the served channel therefore brings the next-best channel to the outputs right after that clock edge. Software is expected to give each channel a distinct rank. If two ranks are equal anyway, the lower channel index wins, so the outcome is always deterministic.

Top module: `rank_irq_arb`

## Requirements
- R1: After reset, no channel is pending, irq is 0, win_idx is 0, the vector base is 0, and each channel's rank equals its own channel index.
- R2: An arrival strobe on channel i at a rising edge makes channel i pending from that edge on, and the pending state is visible on the outputs in the following cycle.
- R3: An acknowledge on channel i at a rising edge clears its pending bit. The next-best pending channel is presented on win_idx and vector right after that edge.
- R4: If arrival and acknowledge hit the same channel at the same edge, the channel remains pending, because the new message wins over the clear.
- R5: irq is 1 exactly when at least one channel is pending.
- R6: While irq is 1, win_idx names a pending channel whose rank is less than or equal to the rank of every other pending channel (a lower rank value means higher priority).
- R7: When pending channels share the smallest rank, the channel with the lowest index wins.
- R8: With rank_we high at an edge, the 4-bit rank of channel rank_sel becomes rank_val, and the new rank takes part in arbitration from the next cycle.
- R9: vector equals the vector base with bits 2..0 replaced by win_idx. When nothing is pending, win_idx is 0.
- R10: With base_we high at an edge, the vector base takes base_val, and vector bits 7..3 show base_val bits 7..3 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive | input | 8 | Per-channel message-arrival strobe |
| ack | input | 8 | Per-channel acknowledge, clears pending |
| rank_we | input | 1 | Rank write enable |
| rank_sel | input | 3 | Channel whose rank is written |
| rank_val | input | 4 | Rank value written |
| base_we | input | 1 | Vector base write enable |
| base_val | input | 8 | Vector base value written |
| irq | output | 1 | Interrupt request, any channel pending |
| win_idx | output | 3 | Index of the winning channel |
| vector | output | 8 | Vector base with winning index in low bits |

## Verification
Three things can fall in the same cycle: a channel's arrival and its own acknowledge, a rank rewrite and arbitration among pending channels, and an acknowledge of the current winner together with an arrival on another channel. The bench drives each of these pairs at a single edge. It then compares irq, win_idx and vector after that edge against a model that applies the clear before the set and searches the ranks linearly. The first pair shows whether the new message survives the clear. The second and third show that the winner is chosen from the updated state, one cycle later.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int CH_N  = 8;
  localparam int RK_W  = 4;
  localparam int VEC_W = 8;
  localparam int IX_W  = $clog2(CH_N);

  typedef struct packed {
    logic            vld;
    logic [RK_W-1:0] rank;
    logic [IX_W-1:0] idx;
  } cand_t;

  // Left operand always covers lower channel indices: ties keep it.
  function automatic cand_t pick(cand_t lo, cand_t hi);
    if (lo.vld && (!hi.vld || lo.rank <= hi.rank)) return lo;
    return hi;
  endfunction

  function automatic logic [VEC_W-1:0] mk_vec(logic [VEC_W-1:0] base,
                                              logic [IX_W-1:0]  ix);
    return {base[VEC_W-1:IX_W], ix};
  endfunction
endpackage

// File: rtl/pend_bank.sv
module pend_bank #(
  parameter int NCH = arb_pkg::CH_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] arrive,
  input  logic [NCH-1:0] ack,
  output logic [NCH-1:0] pend
);
  // Clear first, then set: a fresh arrival survives a same-edge ack.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~ack) | arrive;
  end
endmodule

// File: rtl/rank_regs.sv
module rank_regs #(
  parameter int NCH  = arb_pkg::CH_N,
  parameter int RK_W = arb_pkg::RK_W,
  localparam int IX_W = $clog2(NCH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IX_W-1:0]           sel,
  input  logic [RK_W-1:0]           val,
  output logic [NCH-1:0][RK_W-1:0]  ranks
);
  for (genvar i = 0; i < NCH; i++) begin : g_rank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ranks[i] <= RK_W'(i);
      else if (we && sel == IX_W'(i))      ranks[i] <= val;
    end
  end
endmodule

// File: rtl/rank_tree.sv
module rank_tree #(
  parameter int NCH  = arb_pkg::CH_N,
  parameter int RK_W = arb_pkg::RK_W,
  localparam int IX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]           pend,
  input  logic [NCH-1:0][RK_W-1:0] ranks,
  output arb_pkg::cand_t           root
);
  import arb_pkg::*;
  cand_t node [1:2*NCH-1];

  // Heap layout: leaves at NCH..2*NCH-1, node k merges 2k (lower) and 2k+1.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      node[NCH+i].vld  = pend[i];
      node[NCH+i].rank = ranks[i];
      node[NCH+i].idx  = IX_W'(i);
    end
    for (int k = NCH-1; k >= 1; k--) begin
      node[k] = pick(node[2*k], node[2*k+1]);
    end
    root = node[1];
  end
endmodule

// File: rtl/rank_irq_arb.sv
module rank_irq_arb #(
  parameter int NCH   = arb_pkg::CH_N,
  parameter int RK_W  = arb_pkg::RK_W,
  parameter int VEC_W = arb_pkg::VEC_W,
  localparam int IX_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   arrive,
  input  logic [NCH-1:0]   ack,
  input  logic             rank_we,
  input  logic [IX_W-1:0]  rank_sel,
  input  logic [RK_W-1:0]  rank_val,
  input  logic             base_we,
  input  logic [VEC_W-1:0] base_val,
  output logic             irq,
  output logic [IX_W-1:0]  win_idx,
  output logic [VEC_W-1:0] vector
);
  import arb_pkg::*;

  logic [NCH-1:0]           pend_q;
  logic [NCH-1:0][RK_W-1:0] rank_q;
  logic [VEC_W-1:0]         base_q;
  cand_t                    best;

  pend_bank #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .arrive(arrive), .ack(ack), .pend(pend_q));

  rank_regs #(.NCH(NCH), .RK_W(RK_W)) u_rank (
    .clk(clk), .rst_n(rst_n), .we(rank_we), .sel(rank_sel),
    .val(rank_val), .ranks(rank_q));

  rank_tree #(.NCH(NCH), .RK_W(RK_W)) u_tree (
    .pend(pend_q), .ranks(rank_q), .root(best));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_val;
  end

  assign irq     = best.vld;
  assign win_idx = best.vld ? best.idx : '0;
  assign vector  = mk_vec(base_q, win_idx);
endmodule

// File: rtl/rank_irq_arb_chk.sv
module rank_irq_arb_chk #(
  parameter int NCH   = arb_pkg::CH_N,
  parameter int RK_W  = arb_pkg::RK_W,
  parameter int VEC_W = arb_pkg::VEC_W,
  localparam int IX_W = $clog2(NCH)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            arrive,
  input logic [NCH-1:0]            ack,
  input logic                      base_we,
  input logic [VEC_W-1:0]          base_val,
  input logic                      irq,
  input logic [IX_W-1:0]           win_idx,
  input logic [VEC_W-1:0]          vector,
  input logic [NCH-1:0]            pend_q,
  input logic [NCH-1:0][RK_W-1:0]  rank_q
);
  AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (pend_q != '0)); // R5

  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend_q[win_idx]); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> win_idx == '0); // R9

  AST_VEC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    vector[IX_W-1:0] == win_idx); // R9

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(base_we)) |->
      vector[VEC_W-1:IX_W] == $past(base_val[VEC_W-1:IX_W])); // R10

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    AST_RANK_BEST: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && pend_q[j]) |-> rank_q[win_idx] <= rank_q[j]); // R6

    AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && pend_q[j] && rank_q[j] == rank_q[win_idx]) |->
        IX_W'(j) >= win_idx); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(arrive[j])) |-> pend_q[j]); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ack[j] && !arrive[j])) |-> !pend_q[j]); // R3
  end
endmodule

bind rank_irq_arb rank_irq_arb_chk #(.NCH(NCH), .RK_W(RK_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arrive(arrive), .ack(ack),
  .base_we(base_we), .base_val(base_val), .irq(irq), .win_idx(win_idx),
  .vector(vector), .pend_q(pend_q), .rank_q(rank_q));

// File: tb/sim_rank_irq_arb.sv
module sim_rank_irq_arb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] arrive = '0, ack = '0;
  logic       rank_we = 1'b0, base_we = 1'b0;
  logic [2:0] rank_sel = '0;
  logic [3:0] rank_val = '0;
  logic [7:0] base_val = '0;
  logic       irq;
  logic [2:0] win_idx;
  logic [7:0] vector;

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0] pend_m = '0;
  logic [3:0] rank_m [8];
  logic [7:0] base_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_irq_arb u0 (
    .clk(clk), .rst_n(rst_n), .arrive(arrive), .ack(ack),
    .rank_we(rank_we), .rank_sel(rank_sel), .rank_val(rank_val),
    .base_we(base_we), .base_val(base_val),
    .irq(irq), .win_idx(win_idx), .vector(vector));

  function automatic logic [2:0] ref_win();
    logic [2:0] w = '0;
    logic       found = 1'b0;
    for (int i = 0; i < 8; i++)
      if (pend_m[i] && (!found || rank_m[i] < rank_m[w])) begin
        w = 3'(i); found = 1'b1;
      end
    return w;
  endfunction

  task automatic check(string tag);
    logic       e_irq = (pend_m != 0);
    logic [2:0] e_w   = ref_win();
    logic [7:0] e_v   = {base_m[7:3], e_w};
    checks++;
    if (irq !== e_irq || win_idx !== e_w || vector !== e_v) begin
      failures++;
      $display("FAIL %s: irq=%0b win=%0d vec=%02h expected irq=%0b win=%0d vec=%02h",
               tag, irq, win_idx, vector, e_irq, e_w, e_v);
    end
  endtask

  // One clock: drive at the falling edge, update model at the rising edge.
  task automatic step(logic [7:0] arr, logic [7:0] ak, logic rwe,
                      logic [2:0] rs, logic [3:0] rv, logic bwe, logic [7:0] bv);
    @(negedge clk);
    arrive = arr; ack = ak; rank_we = rwe; rank_sel = rs; rank_val = rv;
    base_we = bwe; base_val = bv;
    @(posedge clk);
    pend_m = (pend_m & ~ak) | arr;
    if (rwe) rank_m[rs] = rv;
    if (bwe) base_m = bv;
    #1;
    arrive = '0; ack = '0; rank_we = 1'b0; base_we = 1'b0;
  endtask

  task automatic t_reset();
    #1; check("R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset");
    step(8'hFF, 8'h00, 0, 0, 0, 0, 0);
    check("R1 reset ranks follow index");
    step(8'h00, 8'hFF, 0, 0, 0, 0, 0);
    check("R5 idle after drain");
  endtask

  task automatic t_arrive();
    step(8'h20, 8'h00, 0, 0, 0, 0, 0);
    check("R2 single arrival");
    step(8'h00, 8'h20, 0, 0, 0, 0, 0);
    check("R5 drop after ack");
  endtask

  task automatic t_rank();
    logic [3:0] rv [8] = '{4'd9, 4'd3, 4'd7, 4'd1, 4'd12, 4'd0, 4'd5, 4'd2};
    for (int i = 0; i < 8; i++) step(0, 0, 1, 3'(i), rv[i], 0, 0);
    step(8'b0101_0111, 0, 0, 0, 0, 0, 0);
    check("R6 lowest rank wins");
    step(8'h00, 8'h02, 0, 0, 0, 0, 0);
    check("R3 next best after ack");
    step(8'h08, 8'h00, 0, 0, 0, 0, 0);
    check("R6 new better arrival");
    step(8'h00, 8'h00, 1, 3'd0, 4'd0, 0, 0);
    check("R8 rank rewrite changes winner");
    step(8'h80, 8'h01, 0, 0, 0, 0, 0);
    check("R3 ack winner with other arrival");
    step(0, 8'hFF, 0, 0, 0, 0, 0);
    check("R5 drained");
  endtask

  task automatic t_tie();
    step(0, 0, 1, 3'd2, 4'd4, 0, 0);
    step(0, 0, 1, 3'd6, 4'd4, 0, 0);
    step(8'h44, 0, 0, 0, 0, 0, 0);
    check("R7 tie lower index");
    step(0, 8'h04, 0, 0, 0, 0, 0);
    check("R7 tie partner remains");
    step(0, 8'hFF, 0, 0, 0, 0, 0);
  endtask

  task automatic t_same();
    step(8'h10, 0, 0, 0, 0, 0, 0);
    step(8'h10, 8'h10, 0, 0, 0, 0, 0);
    check("R4 arrival beats ack");
    step(0, 8'h10, 0, 0, 0, 0, 0);
    check("R4 plain ack clears");
  endtask

  task automatic t_base();
    step(0, 0, 0, 0, 0, 1, 8'hA8);
    check("R10 base idle vector");
    step(8'h02, 0, 0, 0, 0, 0, 0);
    check("R9 vector with index");
    step(0, 0, 0, 0, 0, 1, 8'h57);
    check("R10 base low bits replaced");
    step(0, 8'h02, 0, 0, 0, 0, 0);
    check("R9 idle index zero");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT) begin
      failures++; checks++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) rank_m[i] = 4'(i);
    t_reset();
    t_arrive();
    t_rank();
    t_tie();
    t_same();
    t_base();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule